// File: doc/BRIEF.md
# Sampled Quadrature Knob Decoder

This block turns the two phase-shifted contact outputs of a hand-turned detented knob into a signed detent position, a one-cycle step pulse and a direction bit. The contacts are not related to the system clock. Each one first passes through a two-flop synchronizer. The synchronized pair is then looked at only once per sample period. A parameterised prescaler sets that period. For a knob with 16 detents per turn and a worst case of 300 RPM, one detent lasts about 12.5 ms. A sample period of 1 ms or less therefore leaves a wide margin for shock and short bursts of edges, and the decode state is still not clocked at the full system rate.

The sample is compared with the pair stored at the previous change. When they are equal, no decode register is written. When exactly one channel has changed, the fine quadrature phase moves by one step, a step pulse is issued and the direction bit is updated. The detent count moves only when the fine phase wraps, which happens once per four quadrature steps. When both channels have changed between two samples, the transition cannot be decoded. It sets a sticky fault flag and produces no step. A contact that chatters on the edge where the knob came to rest therefore gives only alternating up and down steps, and the net count does not change.

Top module: `knob_quad_decoder`

## Requirements
- R1: Decode state (stored pair, fine phase, detent, direction) changes only in the cycle after a sample tick. A tick occurs once every PRESCALE clock cycles, and each input passes two synchronizer flops before it is sampled.
- R2: The pair {B,A} is read as a Gray position: 00=0, 01=1, 11=2, 10=3. A change that raises the position by one (00→01→11→10→00, A leading B) gives one step pulse with dir_o=1 and raises the fine phase by one.
- R3: A change that lowers the position by one (B leading A) gives one step pulse with dir_o=0 and lowers the fine phase by one.
- R4: The detent count rises by one when the fine phase wraps from 3 to 0 and falls by one when it wraps from 0 to 3. It never changes at any other time, and it wraps in two's complement, so one step down from zero reads all ones.
- R5: Chatter on one channel at a rest position gives strictly alternating up and down steps, and the detent count returns to its starting value.
- R6: A sample in which both channels differ from the stored pair sets fault_o, which stays set until reset. That sample gives no step and leaves the detent and the fine phase unchanged.
- R7: A sample equal to the stored pair leaves every decode register unchanged and gives no step pulse.
- R8: Reset clears the detent count, the fine phase, the stored pair (to 00), dir_o, step_o and fault_o.
- R9: step_o is high for exactly one clock cycle per decoded step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| chan_a_i | input | 1 | Knob channel A, asynchronous |
| chan_b_i | input | 1 | Knob channel B, asynchronous |
| step_o | output | 1 | One-cycle pulse per decoded quadrature step |
| dir_o | output | 1 | Direction of the last step, 1 = up |
| detent_o | output | POS_W | Signed detent position |
| fault_o | output | 1 | Sticky flag for a two-channel change |

## Verification
A wrong fine phase does not appear at once. It appears one to three quadrature steps later, when the detent count moves at the wrong position or moves in the wrong direction. For that reason the bench checks the detent value after every single step around two full detents, in both directions. A stored pair that is corrupted appears within one sample period, either as a false fault or as a step with the wrong direction. The chatter, idle and fault cases confirm that the detent and the step tallies return to, or keep, their earlier values once the sample period has settled.

// File: rtl/knob_quad_decoder.sv
module knob_quad_decoder #(
  parameter int PRESCALE = 6000,
  parameter int POS_W    = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chan_a_i,
  input  logic                    chan_b_i,
  output logic                    step_o,
  output logic                    dir_o,
  output logic signed [POS_W-1:0] detent_o,
  output logic                    fault_o
);

  localparam int PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [1:0]      sync_a, sync_b;
  logic [PS_W-1:0] div_q;
  logic [1:0]      prev_q, fine_q;
  logic [1:0]      pair, delta;
  logic            tick, fwd, back, bad;

  function automatic logic [1:0] gray_pos(input logic [1:0] p);
    return {p[1], p[1] ^ p[0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= {sync_a[0], chan_a_i};
      sync_b <= {sync_b[0], chan_b_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;

  assign tick  = (div_q == PS_LAST);
  assign pair  = {sync_b[1], sync_a[1]};
  assign delta = gray_pos(pair) - gray_pos(prev_q);
  assign fwd   = tick && (delta == 2'd1);
  assign back  = tick && (delta == 2'd3);
  assign bad   = tick && (delta == 2'd2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q   <= '0;
      fine_q   <= '0;
      detent_o <= '0;
      dir_o    <= 1'b0;
      fault_o  <= 1'b0;
      step_o   <= 1'b0;
    end else begin
      step_o <= fwd || back;
      if (fwd || back || bad) prev_q <= pair;
      if (bad) fault_o <= 1'b1;
      if (fwd) begin
        fine_q <= fine_q + 2'd1;
        dir_o  <= 1'b1;
        if (fine_q == 2'd3) detent_o <= detent_o + 1'b1;
      end
      if (back) begin
        fine_q <= fine_q - 2'd1;
        dir_o  <= 1'b0;
        if (fine_q == 2'd0) detent_o <= detent_o - 1'b1;
      end
    end

  assert_sample_only_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(detent_o) && $stable(dir_o) && $stable(prev_q) && $stable(fine_q)));

  assert_up_step_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && dir_o) |-> (fine_q == $past(fine_q) + 2'd1));

  assert_down_step_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !dir_o) |-> (fine_q == $past(fine_q) - 2'd1));

  assert_detent_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (detent_o != $past(detent_o)) |->
      (($past(fine_q) == 2'd3 && fine_q == 2'd0) || ($past(fine_q) == 2'd0 && fine_q == 2'd3)));

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);

  assert_no_step_on_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> (!step_o && $stable(detent_o) && $stable(fine_q)));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $past(pair) == $past(prev_q)) |->
      (!step_o && $stable(prev_q) && $stable(fine_q) && $stable(detent_o)));

  assert_step_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o);

endmodule

// File: tb/tb_knob_quad_decoder.sv
module tb_knob_quad_decoder;
  localparam int PS = 4;
  localparam int PW = 8;
  localparam int HOLD = 16;

  logic clk = 1'b0, rst_n = 1'b0, a = 1'b0, b = 1'b0;
  logic step, dir, fault;
  logic signed [PW-1:0] det;
  int checks = 0, errors = 0, ups = 0, downs = 0;

  always #2 clk = ~clk;

  knob_quad_decoder #(.PRESCALE(PS), .POS_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .chan_a_i(a), .chan_b_i(b),
    .step_o(step), .dir_o(dir), .detent_o(det), .fault_o(fault));

  always @(negedge clk)
    if (rst_n && step) begin
      if (dir) ups++;
      else     downs++;
    end

  // {B,A} pair, expected detent, expected dir
  localparam logic [10:0] VEC [16] = '{
    {2'b01, 8'sd0, 1'b1}, {2'b11, 8'sd0, 1'b1}, {2'b10, 8'sd0, 1'b1}, {2'b00, 8'sd1, 1'b1},
    {2'b01, 8'sd1, 1'b1}, {2'b11, 8'sd1, 1'b1}, {2'b10, 8'sd1, 1'b1}, {2'b00, 8'sd2, 1'b1},
    {2'b10, 8'sd1, 1'b0}, {2'b11, 8'sd1, 1'b0}, {2'b01, 8'sd1, 1'b0}, {2'b00, 8'sd1, 1'b0},
    {2'b10, 8'sd0, 1'b0}, {2'b11, 8'sd0, 1'b0}, {2'b01, 8'sd0, 1'b0}, {2'b00, 8'sd0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] p);
    @(negedge clk);
    {b, a} = p;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {b, a} = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ups = 0;
    downs = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int eu = 0, ed = 0, up0, dn0;
    do_reset();
    @(negedge clk);
    check("R8 detent after reset", det, 0);
    check("R8 fault after reset", fault, 0);
    check("R8 step after reset", step, 0);
    check("R8 dir after reset", dir, 0);

    // R2 R3 R4 R9: walk two detents up and back
    for (int i = 0; i < 16; i++) begin
      apply(VEC[i][10:9]);
      if (VEC[i][0]) eu++; else ed++;
      check("R4 detent per vector", det, {{24{VEC[i][8]}}, VEC[i][8:1]});
      check(VEC[i][0] ? "R2 dir up" : "R3 dir down", dir, VEC[i][0]);
      check("R9 up pulses", ups, eu);
      check("R9 down pulses", downs, ed);
    end

    // R5: chatter on channel B at the detent edge (00 <-> 10)
    for (int k = 0; k < 5; k++) begin
      apply(2'b10);
      check("R5 chatter low side", det, 32'hFFFF_FFFF);
      apply(2'b00);
      check("R5 chatter back", det, 0);
    end
    check("R5 net steps balance", ups - downs, 0);

    // R7: no input change, no step and no motion
    up0 = ups; dn0 = downs;
    repeat (100) @(negedge clk);
    check("R7 idle no up steps", ups, up0);
    check("R7 idle no down steps", downs, dn0);
    check("R7 idle detent held", det, 0);

    // R1: a change is not seen before the sync and the next tick
    @(negedge clk);
    {b, a} = 2'b01;
    @(negedge clk);
    check("R1 no step within one cycle", ups, up0);
    repeat (HOLD) @(negedge clk);
    check("R1 step after sample", ups, up0 + 1);
    apply(2'b00);

    // R6: both channels change in one sample
    up0 = ups; dn0 = downs;
    apply(2'b11);
    check("R6 fault set", fault, 1);
    check("R6 no up step", ups, up0);
    check("R6 no down step", downs, dn0);
    check("R6 detent held", det, 0);
    apply(2'b01);
    check("R6 fault sticky", fault, 1);

    // R8: reset clears the fault; R4: wrap below zero
    do_reset();
    @(negedge clk);
    check("R8 fault cleared", fault, 0);
    check("R8 detent cleared", det, 0);
    apply(2'b10);
    check("R4 detent wraps to all ones", det, 32'hFFFF_FFFF);
    check("R3 dir after down", dir, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule